// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Gain Updater

This block sits in front of a stereo volume stage. Software writes an 8-bit attenuation code to either channel, using 0.5 dB per step, together with a zero-cross enable bit and a mute bit. The block decides when each new code becomes the active gain. With zero-cross off, the code takes effect at once. With zero-cross on, the code waits as pending until that channel's signed input is at or near zero. If no such moment comes, a master-clock timeout forces the change. A global timeout-disable input turns the forced change off.

A global link input makes the right channel follow the left channel's active code. Each channel has its own mute, which forces its output sample to zero. Gain updates carry on while a channel is muted. The active code of each channel is brought out together with a one-cycle update pulse, so the exact cycle of every change can be seen.

Top module: `zc_gain_updater`

## Requirements
- R1: After reset, both active codes read 8'hCF (0 dB), the update pulses are low, mute is off and both output samples are zero.
- R2: A channel write with the zero-cross bit at 0 makes the written code active on the next clock edge, and that channel's update pulse is high for exactly the cycle after that edge.
- R3: A channel write with the zero-cross bit at 1 leaves the active code unchanged and holds the code as pending. The pending code is applied on a clock edge where `smp_valid` is high and the sign bit of that channel's sample differs from the sign bit of its previous valid sample. Before the first valid sample, the previous sign counts as non-negative.
- R4: A pending code is also applied on a clock edge where `smp_valid` is high and the sample's magnitude is below `NEAR_TH`.
- R5: With `tmo_dis` low, a pending code that sees no zero event is applied on the TIMEOUT-th clock edge after its write edge.
- R6: With `tmo_dis` high, a pending code is never forced. It waits for a zero event from R3 or R4.
- R7: A further write to a channel replaces its pending code and restarts its timeout. Only the last code written is ever applied. A write on the same edge as a zero event takes priority over that event.
- R8: While `link` is high, `gain_r` and `upd_r` show the left channel's active code and update pulse. Lowering `link` shows the right channel's own active code again.
- R9: A write sets that channel's mute from `wr_mute`. While mute is set, the channel's output sample is zero. Gain updates still take place, and clearing mute shows the held sample again.
- R10: Each output sample is the channel's input registered on an edge where `smp_valid` is high. It holds its value between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_left | input | 1 | Write strobe for the left channel |
| wr_right | input | 1 | Write strobe for the right channel |
| wr_code | input | GW | Attenuation code to write |
| wr_zc | input | 1 | Zero-cross enable for the write |
| wr_mute | input | 1 | Mute value for the write |
| link | input | 1 | Right channel follows the left code |
| tmo_dis | input | 1 | Disables the timeout-forced update |
| smp_valid | input | 1 | Input sample strobe |
| smp_l | input | SW | Left signed input sample |
| smp_r | input | SW | Right signed input sample |
| gain_l | output | GW | Left active code |
| gain_r | output | GW | Right active code (left's when linked) |
| upd_l | output | 1 | Left update pulse |
| upd_r | output | 1 | Right update pulse |
| out_l | output | SW | Left output sample, zero when muted |
| out_r | output | SW | Right output sample, zero when muted |

## Verification
Several internal faults show up at the active-code port on the very edge where a zero event or a timeout should move the code: a stale pending code, a lost pending flag, or a wrong previous sign. The code then changes one edge too early, one edge too late, or not at all. A timeout counter that is off by one shows at the TIMEOUT-th edge, so the bench uses a short timeout. A mute bit held in the wrong state shows at the sample outputs on the edge after the write. A behavioural model compared on every clock finds each of these faults within the cycle in which it appears.

// File: rtl/zc_gain_updater.sv
module zc_gain_updater #(
  parameter int GW = 8,
  parameter int SW = 16,
  parameter int TIMEOUT = 131072,
  parameter int NEAR_TH = 16,
  parameter logic [GW-1:0] RST_CODE = 8'hCF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_left,
  input  logic                 wr_right,
  input  logic [GW-1:0]        wr_code,
  input  logic                 wr_zc,
  input  logic                 wr_mute,
  input  logic                 link,
  input  logic                 tmo_dis,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_l,
  input  logic signed [SW-1:0] smp_r,
  output logic [GW-1:0]        gain_l,
  output logic [GW-1:0]        gain_r,
  output logic                 upd_l,
  output logic                 upd_r,
  output logic signed [SW-1:0] out_l,
  output logic signed [SW-1:0] out_r
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  logic [1:0]           wr_ch;
  logic signed [SW-1:0] smp_in [2];
  logic [SW:0]          mag [2];
  logic [1:0]           near, fire;

  logic [GW-1:0]        act_q [2];
  logic [GW-1:0]        pend_q [2];
  logic [CW-1:0]        cnt_q [2];
  logic signed [SW-1:0] smp_q [2];
  logic [1:0]           pv_q, mute_q, upd_q, prev_neg_q;

  assign wr_ch     = {wr_right, wr_left};
  assign smp_in[0] = smp_l;
  assign smp_in[1] = smp_r;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      mag[i]  = smp_in[i][SW-1] ? ((SW+1)'(0) - {smp_in[i][SW-1], smp_in[i]})
                                : {1'b0, smp_in[i]};
      near[i] = smp_valid && ((smp_in[i][SW-1] != prev_neg_q[i]) || (mag[i] < (SW+1)'(NEAR_TH)));
      fire[i] = pv_q[i] && !wr_ch[i] && (near[i] || (!tmo_dis && cnt_q[i] == CNT_LAST));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        act_q[i]  <= RST_CODE;
        pend_q[i] <= RST_CODE;
        cnt_q[i]  <= '0;
        smp_q[i]  <= '0;
      end
      pv_q       <= '0;
      mute_q     <= '0;
      upd_q      <= '0;
      prev_neg_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        upd_q[i] <= 1'b0;
        if (smp_valid) begin
          prev_neg_q[i] <= smp_in[i][SW-1];
          smp_q[i]      <= smp_in[i];
        end
        if (wr_ch[i]) begin
          mute_q[i] <= wr_mute;
          cnt_q[i]  <= '0;
          if (wr_zc) begin
            pend_q[i] <= wr_code;
            pv_q[i]   <= 1'b1;
          end else begin
            act_q[i]  <= wr_code;
            pv_q[i]   <= 1'b0;
            upd_q[i]  <= 1'b1;
          end
        end else if (fire[i]) begin
          act_q[i] <= pend_q[i];
          pv_q[i]  <= 1'b0;
          upd_q[i] <= 1'b1;
          cnt_q[i] <= '0;
        end else if (pv_q[i] && cnt_q[i] != CNT_LAST) begin
          cnt_q[i] <= cnt_q[i] + 1'b1;
        end
      end
    end
  end

  assign gain_l = act_q[0];
  assign gain_r = link ? act_q[0] : act_q[1];
  assign upd_l  = upd_q[0];
  assign upd_r  = link ? upd_q[0] : upd_q[1];
  assign out_l  = mute_q[0] ? '0 : smp_q[0];
  assign out_r  = mute_q[1] ? '0 : smp_q[1];

  p_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_left && !wr_zc |=> gain_l == $past(wr_code));

  p_change_flagged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q[0] != $past(act_q[0])) |-> upd_q[0]);

  p_zc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_left && wr_zc |=> $stable(gain_l));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[0] <= CNT_LAST && cnt_q[1] <= CNT_LAST);

  p_no_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_dis && !wr_left && !smp_valid |=> $stable(act_q[0]));

  p_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_right && wr_mute |=> out_r == '0);
endmodule

// File: tb/zc_gain_updater_tb.sv
module zc_gain_updater_tb_top;
  localparam int TO = 40;
  localparam int TH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_left, wr_right, wr_zc, wr_mute, link, tmo_dis, smp_valid;
  logic [7:0] wr_code, gain_l, gain_r;
  logic signed [15:0] smp_l, smp_r, out_l, out_r;
  logic upd_l, upd_r;

  zc_gain_updater #(.TIMEOUT(TO), .NEAR_TH(TH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_left(wr_left), .wr_right(wr_right),
    .wr_code(wr_code), .wr_zc(wr_zc), .wr_mute(wr_mute), .link(link),
    .tmo_dis(tmo_dis), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
    .gain_l(gain_l), .gain_r(gain_r), .upd_l(upd_l), .upd_r(upd_r),
    .out_l(out_l), .out_r(out_r));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_act[2], m_pend[2], m_pv[2], m_mute[2], m_age[2], m_smp[2], m_neg[2], m_upd[2];

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_act[c] = 207; m_pend[c] = 207; m_pv[c] = 0; m_mute[c] = 0;
      m_age[c] = 0; m_smp[c] = 0; m_neg[c] = 0; m_upd[c] = 0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      int s, a;
      bit w, nz;
      s  = (c == 0) ? int'(smp_l) : int'(smp_r);
      w  = (c == 0) ? wr_left : wr_right;
      a  = (s < 0) ? -s : s;
      nz = smp_valid && ((int'(s < 0) != m_neg[c]) || a < TH);
      m_upd[c] = 0;
      if (smp_valid) begin m_neg[c] = int'(s < 0); m_smp[c] = s; end
      if (w) begin
        m_mute[c] = wr_mute; m_age[c] = 0;
        if (wr_zc) begin m_pend[c] = wr_code; m_pv[c] = 1; end
        else begin m_act[c] = wr_code; m_pv[c] = 0; m_upd[c] = 1; end
      end else if (m_pv[c] != 0 && (nz || (!tmo_dis && m_age[c] == TO - 1))) begin
        m_act[c] = m_pend[c]; m_pv[c] = 0; m_upd[c] = 1; m_age[c] = 0;
      end else if (m_pv[c] != 0 && m_age[c] < TO - 1) begin
        m_age[c]++;
      end
    end
  endtask

  task automatic compare();
    chk("R3 gain_l vs model", int'(gain_l), m_act[0]);
    chk("R8 gain_r vs model", int'(gain_r), link ? m_act[0] : m_act[1]);
    chk("R2 upd_l vs model", int'(upd_l), m_upd[0]);
    chk("R8 upd_r vs model", int'(upd_r), link ? m_upd[0] : m_upd[1]);
    chk("R10 out_l vs model", int'(out_l), m_mute[0] != 0 ? 0 : m_smp[0]);
    chk("R9 out_r vs model", int'(out_r), m_mute[1] != 0 ? 0 : m_smp[1]);
  endtask

  task automatic idle();
    wr_left = 0; wr_right = 0; wr_zc = 0; wr_mute = 0; wr_code = 0; smp_valid = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    model_step();
    compare();
    idle();
  endtask

  task automatic wr(input bit right, input int code, input bit zc, input bit mute);
    wr_left = !right; wr_right = right; wr_code = code[7:0]; wr_zc = zc; wr_mute = mute;
  endtask

  task automatic sample(input int l, input int r);
    smp_valid = 1; smp_l = l[15:0]; smp_r = r[15:0];
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); link = 0; tmo_dis = 0; smp_l = 0; smp_r = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset gain_l", int'(gain_l), 207);
    chk("R1 reset gain_r", int'(gain_r), 207);
    chk("R1 reset upd", int'(upd_l) + int'(upd_r), 0);
    chk("R1 reset out", int'(out_l) + int'(out_r), 0);
    rst_n = 1;
    tick();

    wr(0, 8'h10, 0, 0); tick();
    chk("R2 immediate gain", int'(gain_l), 8'h10);
    chk("R2 pulse high", int'(upd_l), 1);
    tick();
    chk("R2 pulse one cycle", int'(upd_l), 0);

    sample(100, 0); tick();
    wr(0, 8'h20, 1, 0); tick();
    chk("R3 pending not applied", int'(gain_l), 8'h10);
    sample(100, 0); tick();
    chk("R3 same sign holds", int'(gain_l), 8'h10);
    sample(-100, 0); tick();
    chk("R3 sign change applies", int'(gain_l), 8'h20);
    chk("R3 pulse", int'(upd_l), 1);

    wr(0, 8'h30, 1, 0); tick();
    sample(-100, 0); tick();
    chk("R4 large magnitude holds", int'(gain_l), 8'h20);
    sample(-5, 0); tick();
    chk("R4 small magnitude applies", int'(gain_l), 8'h30);

    wr(0, 8'h40, 1, 0); tick();
    repeat (TO - 1) tick();
    chk("R5 before timeout", int'(gain_l), 8'h30);
    tick();
    chk("R5 timeout applies", int'(gain_l), 8'h40);
    chk("R5 timeout pulse", int'(upd_l), 1);

    wr(0, 8'h50, 1, 0); tick();
    repeat (20) tick();
    wr(0, 8'h60, 1, 0); tick();
    repeat (TO - 1) tick();
    chk("R7 restarted timeout holds", int'(gain_l), 8'h40);
    tick();
    chk("R7 latest code applied", int'(gain_l), 8'h60);

    tmo_dis = 1;
    wr(0, 8'h70, 1, 0); tick();
    repeat (2 * TO) tick();
    chk("R6 no forced update", int'(gain_l), 8'h60);
    sample(50, 0); tick();
    chk("R6 zero event applies", int'(gain_l), 8'h70);
    tmo_dis = 0;

    link = 1;
    wr(1, 8'h11, 0, 0); tick();
    chk("R8 linked right shows left", int'(gain_r), 8'h70);
    wr(0, 8'h22, 0, 0); tick();
    chk("R8 linked follows left", int'(gain_r), 8'h22);
    chk("R8 linked pulse", int'(upd_r), 1);
    link = 0; tick();
    chk("R8 unlinked own code", int'(gain_r), 8'h11);

    sample(50, 300); tick();
    chk("R10 registered sample", int'(out_r), 300);
    tick();
    chk("R10 sample held", int'(out_r), 300);
    wr(1, 8'h33, 0, 1); tick();
    chk("R9 muted output", int'(out_r), 0);
    chk("R9 gain updates while muted", int'(gain_r), 8'h33);
    wr(1, 8'h33, 0, 0); tick();
    chk("R9 unmute restores", int'(out_r), 300);

    for (int k = 0; k < 3000; k++) begin
      if (k % 150 == 0) begin link = ($urandom % 3) == 0; tmo_dis = ($urandom % 3) == 0; end
      wr_left   = ($urandom % 9) == 0;
      wr_right  = ($urandom % 9) == 0;
      wr_zc     = ($urandom % 4) != 0;
      wr_mute   = ($urandom % 6) == 0;
      wr_code   = 8'($urandom);
      smp_valid = ($urandom % 5) == 0;
      smp_l     = 16'(int'($urandom % 64) - 32);
      smp_r     = 16'(int'($urandom % 64) - 32);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule